// File: doc/BRIEF.md
# USB Low/Full-Speed Line Receiver

This block watches the two raw wires of a USB low-speed or full-speed link. It samples them with a clock several times faster than the bit rate. Each sample is turned into a line state (J, K, SE0 or SE1). A speed-mode input sets which differential polarity counts as J. The block does not regenerate a bit clock. It measures how many samples each line state lasted and converts that length into a whole number of bit periods, using a fixed-point reciprocal of the samples-per-bit ratio that is fixed at compile time.

Each interval between line changes is turned into NRZI-decoded bits. An interval of k bit times gives k-1 ones, followed by one zero for the transition itself. A run of exactly six ones marks a stuffed bit, and its transition adds no zero. The bits leave the block one per clock as a qualified serial stream. A packet-active flag marks a packet in progress. Single-cycle strobes report end of packet, bus reset and bit-stuff violations. A downstream packet parser consumes the stream and the strobes.

Top module: `usbrx_line_rx`

## Requirements
- R1: Line states come from (dp,dm): 00 is SE0 and 11 is SE1 in both modes. With low_speed=0, 10 is J and 01 is K. With low_speed=1 the two are swapped: 01 is J and 10 is K.
- R2: While the line rests in J with no packet active, no bits are produced. The first change away from that idle J emits a single 0 bit, unless the new state is SE0, in which case nothing is emitted.
- R3: Take a line state other than SE0 that lasts k bit times, with k-1 below 6, and ends in a state other than SE0. It yields k-1 bits of value 1 followed by one bit of value 0, delivered in that order on bit_data with bit_valid high.
- R4: When the new state is SE0, the ones of the ending interval are still emitted, but no 0 bit follows them.
- R5: An interval that yields exactly six ones emits the six ones and no 0 bit, because its transition is a stuffed bit.
- R6: An interval that yields more than six ones emits no bits. It pulses stuff_err for one cycle and leaves pkt_active unchanged.
- R7: An SE0 lasting two bit times (one counted bit) pulses eop for one cycle when it ends, but only if pkt_active was set. Otherwise it produces no output at all.
- R8: An SE0 of any other length pulses bus_reset for one cycle when it ends. eop, bus_reset and stuff_err are never high together.
- R9: pkt_active rises with the first emitted bit of a packet and is cleared when any SE0 ends. Bits are only ever emitted while it is set.
- R10: The interval counter saturates at its full width (CNT_W bits). An SE0 long enough to wrap the counter is still reported as bus_reset, never as eop.
- R11: After reset every output is 0. The line is only evaluated once every synchronizer stage holds a sampled value.
- R12: The bit period follows the mode: SAMPLE_HZ/FS_HZ samples per bit at full speed and SAMPLE_HZ/LS_HZ at low speed (4 and 32 at the default values).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock at SAMPLE_HZ |
| rst | input | 1 | Synchronous active-high reset |
| low_speed | input | 1 | 1 selects low-speed rate and polarity, 0 full-speed |
| dp | input | 1 | Raw D+ wire |
| dm | input | 1 | Raw D- wire |
| bit_valid | output | 1 | A decoded bit is on bit_data this cycle |
| bit_data | output | 1 | Decoded, destuffed bit value |
| pkt_active | output | 1 | A packet is in progress |
| eop | output | 1 | One-cycle end-of-packet strobe |
| bus_reset | output | 1 | One-cycle bus reset strobe |
| stuff_err | output | 1 | One-cycle bit-stuff violation strobe |

## Verification
The hardest case to reach from the ports is counter saturation. Only an SE0 longer than the counter's full range shows the difference between saturating and wrapping. The stimulus first opens a packet. It then holds SE0 for 65,544 samples, which is eight samples past the wrap point. A wrapping counter would read that as one bit and raise eop, while the correct design raises bus_reset. The scoreboard also covers the stuffed-bit and over-length runs, which are reached by holding J for exactly seven and eight bit times inside a packet.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

   typedef enum logic [1:0] {
      SYM_SE0 = 2'd0,
      SYM_J   = 2'd1,
      SYM_K   = 2'd2,
      SYM_SE1 = 2'd3
   } line_sym_t;

   // longest legal run of ones before a stuffed transition
   localparam int STUFF_LEN = 6;
   localparam int RUN_W     = $clog2(STUFF_LEN + 1);

   // polarity of the differential pair depends on speed mode
   function automatic line_sym_t classify(input logic p, input logic n,
                                          input logic slow);
      line_sym_t s;
      case ({p, n})
         2'b00:   s = SYM_SE0;
         2'b11:   s = SYM_SE1;
         2'b10:   s = slow ? SYM_K : SYM_J;
         default: s = slow ? SYM_J : SYM_K;
      endcase
      return s;
   endfunction

   // fixed-point bits-per-sample ratio, rounded up
   function automatic longint unsigned bits_per_sample(input longint unsigned bit_hz,
                                                       input longint unsigned smp_hz,
                                                       input int frac);
      return ((bit_hz << frac) + smp_hz - 1) / smp_hz;
   endfunction

endpackage

// File: rtl/usbrx_sync.sv
module usbrx_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         ready
);
   localparam int FW = $clog2(STAGES + 1);
   localparam logic [FW-1:0] FULL = FW'(STAGES);

   logic [W-1:0]  stg [STAGES];
   logic [FW-1:0] fill_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stg[g] <= '0;
               else     stg[g] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) stg[g] <= '0;
               else     stg[g] <= stg[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)                 fill_q <= '0;
      else if (fill_q != FULL) fill_q <= fill_q + 1'b1;
   end

   assign q     = stg[STAGES-1];
   assign ready = (fill_q == FULL);
endmodule

// File: rtl/usbrx_interval.sv
module usbrx_interval #(
   parameter int SAMPLE_HZ = 48_000_000,
   parameter int LS_HZ     = 1_500_000,
   parameter int FS_HZ     = 12_000_000,
   parameter int CNT_W     = 16,
   parameter int FRAC      = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic             clear,
   input  logic             low_speed,
   output logic [CNT_W-1:0] bits
);
   import usbrx_pkg::*;

   localparam int PW = CNT_W + FRAC + 1;
   localparam logic [FRAC:0] R_LS =
      (FRAC+1)'(bits_per_sample(longint'(LS_HZ), longint'(SAMPLE_HZ), FRAC));
   localparam logic [FRAC:0] R_FS =
      (FRAC+1)'(bits_per_sample(longint'(FS_HZ), longint'(SAMPLE_HZ), FRAC));
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [FRAC:0]    ratio;
   logic [PW-1:0]    prod;

   // samples elapsed since the last change, excluding the current one
   always_ff @(posedge clk) begin
      if (rst || !run || clear) cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign ratio = low_speed ? R_LS : R_FS;
   assign prod  = {{(FRAC+1){1'b0}}, cnt_q} * {{CNT_W{1'b0}}, ratio};
   assign bits  = prod[FRAC +: CNT_W];
endmodule

// File: rtl/usbrx_emit.sv
module usbrx_emit #(
   parameter int RUN_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [RUN_W-1:0] ones,
   input  logic             zero,
   output logic             bit_valid,
   output logic             bit_data
);
   logic [RUN_W-1:0] ones_q;
   logic             zero_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ones_q <= '0;
         zero_q <= 1'b0;
      end else if (load) begin
         ones_q <= ones;
         zero_q <= zero;
      end else if (ones_q != '0) begin
         ones_q <= ones_q - 1'b1;
      end else begin
         zero_q <= 1'b0;
      end
   end

   assign bit_valid = (ones_q != '0) || zero_q;
   assign bit_data  = (ones_q != '0);
endmodule

// File: rtl/usbrx_line_rx.sv
module usbrx_line_rx #(
   parameter int SAMPLE_HZ   = 48_000_000,
   parameter int LS_HZ       = 1_500_000,
   parameter int FS_HZ       = 12_000_000,
   parameter int CNT_W       = 16,
   parameter int FRAC        = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic low_speed,
   input  logic dp,
   input  logic dm,
   output logic bit_valid,
   output logic bit_data,
   output logic pkt_active,
   output logic eop,
   output logic bus_reset,
   output logic stuff_err
);
   import usbrx_pkg::*;

   localparam logic [CNT_W-1:0] RUN_LIM = CNT_W'(STUFF_LEN);
   localparam logic [CNT_W-1:0] EOP_LEN = CNT_W'(1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CNT_W < 8) begin : g_bad_cnt
         $error("CNT_W must be at least 8");
      end
      if (FRAC < 8) begin : g_bad_frac
         $error("FRAC must be at least 8");
      end
      if (SAMPLE_HZ < 4 * FS_HZ || FS_HZ <= LS_HZ) begin : g_bad_rate
         $error("sample rate must be at least four samples per full-speed bit");
      end
   endgenerate

   logic [1:0]       sync_q;
   logic             sync_ready;
   line_sym_t        cur_sym, sym_q;
   logic             change;
   logic [CNT_W-1:0] raw_bits, nbits;
   logic             from_se0, over, to_se0;
   logic             load, load_zero, emits;
   logic             pkt_q, eop_q, brst_q, serr_q;

   usbrx_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .d     ({dp, dm}),
      .q     (sync_q),
      .ready (sync_ready)
   );

   assign cur_sym = classify(sync_q[1], sync_q[0], low_speed);
   assign change  = sync_ready && (cur_sym != sym_q);

   usbrx_interval #(
      .SAMPLE_HZ (SAMPLE_HZ),
      .LS_HZ     (LS_HZ),
      .FS_HZ     (FS_HZ),
      .CNT_W     (CNT_W),
      .FRAC      (FRAC)
   ) u_ival (
      .clk       (clk),
      .rst       (rst),
      .run       (sync_ready),
      .clear     (change),
      .low_speed (low_speed),
      .bits      (raw_bits)
   );

   // idle J outside a packet contributes no bit times
   assign nbits     = (pkt_q || sym_q != SYM_J) ? raw_bits : '0;
   assign from_se0  = (sym_q == SYM_SE0);
   assign to_se0    = (cur_sym == SYM_SE0);
   assign over      = (nbits > RUN_LIM);
   assign load_zero = (nbits < RUN_LIM) && !to_se0;
   assign load      = change && !from_se0 && !over;
   assign emits     = load && ((nbits != '0) || load_zero);

   usbrx_emit #(.RUN_W(RUN_W)) u_emit (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .ones      (nbits[RUN_W-1:0]),
      .zero      (load_zero),
      .bit_valid (bit_valid),
      .bit_data  (bit_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sym_q  <= SYM_J;
         pkt_q  <= 1'b0;
         eop_q  <= 1'b0;
         brst_q <= 1'b0;
         serr_q <= 1'b0;
      end else begin
         if (change) sym_q <= cur_sym;
         if (change && from_se0) pkt_q <= 1'b0;
         else if (emits)         pkt_q <= 1'b1;
         eop_q  <= change && from_se0 && (nbits == EOP_LEN) && pkt_q;
         brst_q <= change && from_se0 && (nbits != EOP_LEN);
         serr_q <= change && !from_se0 && over;
      end
   end

   assign pkt_active = pkt_q;
   assign eop        = eop_q;
   assign bus_reset  = brst_q;
   assign stuff_err  = serr_q;
endmodule

// File: rtl/usbrx_line_rx_chk.sv
module usbrx_line_rx_chk (
   input logic clk,
   input logic rst,
   input logic ready,
   input logic bit_valid,
   input logic pkt_active,
   input logic eop,
   input logic bus_reset,
   input logic stuff_err
);
   // R8: the three strobes are mutually exclusive
   p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
      $onehot0({eop, bus_reset, stuff_err}));

   // R9: decoded bits only inside a packet
   p_bits_in_pkt_r9: assert property (@(posedge clk) disable iff (rst)
      bit_valid |-> pkt_active);

   // R7: end of packet only after a packet was open
   p_eop_had_pkt_r7: assert property (@(posedge clk) disable iff (rst)
      eop |-> $past(pkt_active));

   // R9: any SE0 exit closes the packet
   p_end_clears_r9: assert property (@(posedge clk) disable iff (rst)
      (eop || bus_reset) |-> !pkt_active);

   // R11: nothing leaves the block before the synchronizer is full
   p_quiet_until_ready_r11: assert property (@(posedge clk) disable iff (rst)
      !ready |-> !(bit_valid || eop || bus_reset || stuff_err));

   // R6: an error strobe never overlaps the bit stream
   p_err_no_bits_r6: assert property (@(posedge clk) disable iff (rst)
      stuff_err |-> !bit_valid);
endmodule

bind usbrx_line_rx usbrx_line_rx_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .ready      (sync_ready),
   .bit_valid  (bit_valid),
   .pkt_active (pkt_active),
   .eop        (eop),
   .bus_reset  (bus_reset),
   .stuff_err  (stuff_err)
);

// File: tb/sim_usbrx_line_rx.sv
module sim_usbrx_line_rx;
   // symbol codes used by the bench
   localparam int S_SE0 = 0, S_J = 1, S_K = 2, S_SE1 = 3;
   // scoreboard item codes
   localparam int I_ZERO = 0, I_ONE = 1, I_EOP = 2, I_RST = 3, I_ERR = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic low_speed = 1'b0;
   logic dp = 1'b1, dm = 1'b0;
   logic bit_valid, bit_data, pkt_active, eop, bus_reset, stuff_err;

   int total = 0, bad = 0;
   int exp_q[$];
   string tag_q[$];
   int prev_sym = S_J, prev_k = 1, spb = 4;
   bit pkt = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   usbrx_line_rx u0 (
      .clk(clk), .rst(rst), .low_speed(low_speed), .dp(dp), .dm(dm),
      .bit_valid(bit_valid), .bit_data(bit_data), .pkt_active(pkt_active),
      .eop(eop), .bus_reset(bus_reset), .stuff_err(stuff_err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic push(input int code, input string tag);
      exp_q.push_back(code);
      tag_q.push_back(tag);
   endtask

   task automatic got(input int code);
      if (exp_q.size() == 0) begin
         chk(1'b0, "unexpected item", code, -1);
      end else begin
         int e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(code == e, t, code, e);
      end
   endtask

   // monitor: samples away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         if (bit_valid) got(bit_data ? I_ONE : I_ZERO);
         if (eop)       got(I_EOP);
         if (bus_reset) got(I_RST);
         if (stuff_err) got(I_ERR);
      end
   end

   task automatic set_line(input int s);
      case (s)
         S_SE0:   begin dp = 1'b0; dm = 1'b0; end
         S_SE1:   begin dp = 1'b1; dm = 1'b1; end
         S_J:     begin dp = ~low_speed; dm = low_speed; end
         default: begin dp = low_speed; dm = ~low_speed; end
      endcase
   endtask

   // drive one line state for k bit times; expectations for the state it ends
   task automatic seg(input int s, input int k, input string tag);
      int n;
      n = (prev_sym == S_J && !pkt) ? 0 : prev_k - 1;
      if (prev_sym == S_SE0) begin
         if (n == 1) begin
            if (pkt) push(I_EOP, {tag, " R7 eop"});
         end else begin
            push(I_RST, {tag, " R8/R10 reset"});
         end
         pkt = 1'b0;
      end else if (n > 6) begin
         push(I_ERR, {tag, " R6 stuff error"});
      end else begin
         for (int i = 0; i < n; i++) push(I_ONE, {tag, " R3/R5 one"});
         if (n < 6 && s != S_SE0) push(I_ZERO, {tag, " R2/R3 zero"});
         if (n > 0 || (n < 6 && s != S_SE0)) pkt = 1'b1;
      end
      set_line(s);
      repeat (k * spb) @(posedge clk);
      #1;
      chk(pkt_active == pkt, {tag, " R9 pkt_active"}, pkt_active, pkt);
      prev_sym = s;
      prev_k = k;
   endtask

   task automatic do_reset(input logic slow, input int bits_per);
      rst = 1'b1;
      low_speed = slow;
      spb = bits_per;
      set_line(S_J);
      prev_sym = S_J;
      prev_k = 1;
      pkt = 1'b0;
      repeat (5) @(posedge clk);
      #1;
      chk({bit_valid, pkt_active, eop, bus_reset, stuff_err} == 5'b0,
          "R11 reset outputs", {bit_valid, pkt_active, eop, bus_reset, stuff_err}, 0);
      rst = 1'b0;
      repeat (6) @(posedge clk);
      #1;
      chk({bit_valid, pkt_active, eop, bus_reset, stuff_err} == 5'b0,
          "R11 idle after reset", {bit_valid, pkt_active, eop, bus_reset, stuff_err}, 0);
   endtask

   initial begin
      // full-speed mode, 4 samples per bit
      do_reset(1'b0, 4);
      // R1 R2 R3: sync-like pattern, data, end of packet
      seg(S_K, 1, "fs sync"); seg(S_J, 1, "fs sync"); seg(S_K, 1, "fs sync");
      seg(S_J, 1, "fs sync"); seg(S_K, 1, "fs sync"); seg(S_J, 1, "fs sync");
      seg(S_K, 2, "fs sync"); seg(S_J, 3, "fs data"); seg(S_K, 1, "fs data");
      seg(S_SE0, 2, "fs eop R4"); seg(S_J, 4, "fs idle");
      // R5: six ones then stuffed transition
      seg(S_K, 1, "fs stuff"); seg(S_J, 7, "fs stuff R5"); seg(S_K, 2, "fs stuff");
      seg(S_SE0, 2, "fs stuff"); seg(S_J, 4, "fs idle");
      // R6: seven ones is a stuff violation
      seg(S_K, 1, "fs err"); seg(S_J, 8, "fs err R6"); seg(S_K, 1, "fs err");
      seg(S_SE0, 2, "fs err"); seg(S_J, 4, "fs idle");
      // R4: ones before SE0 get no trailing zero
      seg(S_K, 1, "fs toSE0"); seg(S_J, 4, "fs toSE0 R4");
      seg(S_SE0, 2, "fs toSE0"); seg(S_J, 4, "fs idle");
      // R7: short SE0 without a packet is silent
      seg(S_SE0, 2, "fs bare eop R7"); seg(S_J, 4, "fs idle");
      // R8: long SE0 is a bus reset
      seg(S_SE0, 10, "fs reset R8"); seg(S_J, 4, "fs idle");
      // R1: SE1 is a line state of its own
      seg(S_K, 1, "fs se1 R1"); seg(S_SE1, 1, "fs se1 R1"); seg(S_J, 1, "fs se1");
      seg(S_SE0, 2, "fs se1"); seg(S_J, 4, "fs idle");
      // R10: SE0 past the counter wrap point, with a packet open
      seg(S_K, 1, "fs sat"); seg(S_J, 2, "fs sat");
      seg(S_SE0, 16386, "fs sat R10"); seg(S_J, 4, "fs idle");

      // low-speed mode, 32 samples per bit, swapped polarity
      do_reset(1'b1, 32);
      seg(S_K, 1, "ls R12 R1"); seg(S_J, 1, "ls R12"); seg(S_K, 2, "ls R12");
      seg(S_J, 3, "ls R12"); seg(S_SE0, 2, "ls R12 eop"); seg(S_J, 4, "ls idle");
      seg(S_SE0, 10, "ls reset R8"); seg(S_J, 4, "ls idle");

      repeat (20) @(posedge clk);
      #1;
      chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule